// File: doc/BRIEF.md
# Partial Store Lane Generator

This block turns a left or right partial-word store into one write on a byte-writable memory port. It takes an operation select, the register value, the byte address and the byte order, and produces the aligned bus address, a per-byte write enable and a data bus with each register byte already steered to its byte lane. The memory then writes the enabled lanes and leaves the rest alone. Together, a left and a right store complete an unaligned word or doubleword store.

The 32-bit forms are always present. The 64-bit forms are added by a parameter, which also widens the bus to eight lanes. On an eight-lane bus a 32-bit form uses the half of the bus that address bit 2 selects. The core is combinational. A parameter adds one output register stage.

Top module: `pslg_top`

## Requirements
- R1: The lane index k is the address offset inside the unit (the unit is a word for 32-bit forms and a doubleword for 64-bit forms). For big-endian input (`in_big`=1) k equals that offset. For little-endian input k is the offset XOR 3 for words and XOR 7 for doublewords.
- R2: A 32-bit left store (`in_op`=2'b00) writes 4−k bytes. The register's most significant byte goes to the addressed byte. Each next lower register byte goes to the next byte address, counting up for big-endian and down for little-endian.
- R3: A 32-bit right store (`in_op`=2'b01) writes k+1 bytes. The register's least significant byte goes to the addressed byte. Each next higher register byte goes to the next byte address, counting down for big-endian and up for little-endian.
- R4: On a valid, legal operation the lane of the addressed byte is always enabled. Lanes that are not enabled carry zero data.
- R5: The enabled lanes always form one contiguous run inside the aligned unit and never cross its boundary.
- R6: At offset 0, a big-endian left store and a little-endian right store both enable all four lanes of the word.
- R7: When the 64-bit forms are built (`WIDE_EN`=1), a doubleword left store (`in_op`=2'b10) writes 8−k bytes, starting from register bits 63:56. A doubleword right store (`in_op`=2'b11) writes k+1 bytes, starting from bits 7:0.
- R8: `out_addr` is the input address with its low log2(lanes) bits cleared. Lane b carries byte address `out_addr`+b. On an eight-lane bus a 32-bit form uses lanes 0–3 when address bit 2 is 0 and lanes 4–7 when it is 1.
- R9: When the output is not valid, `out_be` is zero. Reset clears `out_valid` and `out_be`.
- R10: With `OUT_REG`=0 the result appears in the same cycle as `in_valid`. With `OUT_REG`=1 it appears one clock later.
- R11: When the 64-bit forms are not built, a doubleword select still gives `out_valid`, but `out_be` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Bit 0: 1 = right, 0 = left. Bit 1: 1 = doubleword, 0 = word |
| in_addr | input | ADDR_W | Byte address of the store |
| in_big | input | 1 | 1 = big-endian, 0 = little-endian |
| in_data | input | 8*NB | Register value (NB = 8 when WIDE_EN, else 4) |
| out_valid | output | 1 | Write request valid |
| out_addr | output | ADDR_W | Bus-aligned address |
| out_be | output | NB | Byte write enable, bit b for lane b |
| out_wdata | output | 8*NB | Lane-steered write data |

## Verification
The bench builds two instances. The first has WIDE_EN=1 and OUT_REG=1. It covers the eight-lane bus, both halves used by 32-bit forms, the doubleword forms and the one-cycle latency. The second has WIDE_EN=0 and OUT_REG=0. It covers the four-lane bus, the same-cycle path and the rejection of a doubleword select. Every offset is swept against both byte orders and both directions, and the results are compared with a model that walks the store byte by byte.

// File: rtl/pslg_pkg.sv
package pslg_pkg;

  // Operation select fields
  localparam int OP_RIGHT_BIT = 0;
  localparam int OP_DBL_BIT   = 1;

  // Is relative lane j inside the written run for offset m?
  // Left big-endian and right little-endian grow upward from m.
  function automatic logic lane_hit(input logic left, input logic big,
                                    input logic [2:0] m, input logic [2:0] j);
    return (left == big) ? (j >= m) : (j <= m);
  endfunction

  // Register byte index that lands on relative lane j
  function automatic logic [2:0] src_sel(input logic left, input logic [2:0] top,
                                         input logic [2:0] m, input logic [2:0] j);
    logic [2:0] d;
    d = (j >= m) ? (j - m) : (m - j);
    return left ? (top - d) : d;
  endfunction

  // True when the set bits of v form one contiguous run (or v is zero)
  function automatic logic contiguous(input logic [7:0] v);
    logic [8:0] low;
    logic [8:0] sum;
    low = {1'b0, v} & (~{1'b0, v} + 9'd1);
    sum = {1'b0, v} + low;
    return (sum & {1'b0, v}) == 9'd0;
  endfunction

endpackage

// File: rtl/pslg_lane_calc.sv
module pslg_lane_calc #(
  parameter bit WIDE_EN = 1'b1,
  parameter int ADDR_W  = 32,
  localparam int NB     = WIDE_EN ? 8 : 4,
  localparam int LW     = $clog2(NB),
  localparam int DW     = 8 * NB
) (
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_big,
  input  logic [DW-1:0]     in_data,
  output logic              calc_ok,
  output logic [ADDR_W-1:0] calc_addr,
  output logic [NB-1:0]     calc_be,
  output logic [DW-1:0]     calc_wdata
);
  import pslg_pkg::*;

  logic       dbl, left;
  logic [2:0] m, top, base;

  assign dbl     = in_op[OP_DBL_BIT];
  assign left    = !in_op[OP_RIGHT_BIT];
  assign top     = dbl ? 3'd7 : 3'd3;
  assign m       = dbl ? in_addr[2:0] : {1'b0, in_addr[1:0]};
  assign calc_ok = !dbl || WIDE_EN;
  assign calc_addr = {in_addr[ADDR_W-1:LW], {LW{1'b0}}};

  generate
    if (NB == 8) begin : g_base8
      assign base = dbl ? 3'd0 : {in_addr[2], 2'b00};
    end else begin : g_base4
      assign base = 3'd0;
    end
  endgenerate

  generate
    for (genvar j = 0; j < NB; j++) begin : g_lane
      logic [2:0] rel, src;
      logic       inu, hit;
      always_comb begin
        rel = 3'(j) - base;
        inu = (3'(j) >= base) && (rel <= top);
        hit = in_valid && calc_ok && inu && lane_hit(left, in_big, m, rel);
        src = src_sel(left, top, m, rel);
      end
      assign calc_be[j]         = hit;
      assign calc_wdata[8*j +: 8] = hit ? in_data[{src[LW-1:0], 3'b000} +: 8] : 8'h00;
    end
  endgenerate

endmodule

// File: rtl/pslg_out_stage.sv
module pslg_out_stage #(
  parameter bit OUT_REG = 1'b1,
  parameter int NB      = 8,
  parameter int ADDR_W  = 32,
  localparam int DW     = 8 * NB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [NB-1:0]     d_be,
  input  logic [DW-1:0]     d_wdata,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output logic [NB-1:0]     q_be,
  output logic [DW-1:0]     q_wdata
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_valid <= 1'b0;
          q_addr  <= '0;
          q_be    <= '0;
          q_wdata <= '0;
        end else begin
          q_valid <= d_valid;
          q_addr  <= d_addr;
          q_be    <= d_be;
          q_wdata <= d_wdata;
        end
      end
    end else begin : g_comb
      assign q_valid = d_valid;
      assign q_addr  = d_addr;
      assign q_be    = d_be;
      assign q_wdata = d_wdata;
    end
  endgenerate
endmodule

// File: rtl/pslg_top.sv
module pslg_top #(
  parameter bit WIDE_EN = 1'b1,
  parameter bit OUT_REG = 1'b1,
  parameter int ADDR_W  = 32,
  localparam int NB     = WIDE_EN ? 8 : 4,
  localparam int LW     = $clog2(NB),
  localparam int DW     = 8 * NB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_big,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [NB-1:0]     out_be,
  output logic [DW-1:0]     out_wdata
);
  import pslg_pkg::*;

  logic              calc_ok;
  logic [ADDR_W-1:0] calc_addr;
  logic [NB-1:0]     calc_be;
  logic [DW-1:0]     calc_wdata;

  pslg_lane_calc #(.WIDE_EN(WIDE_EN), .ADDR_W(ADDR_W)) u_calc (
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_addr   (in_addr),
    .in_big    (in_big),
    .in_data   (in_data),
    .calc_ok   (calc_ok),
    .calc_addr (calc_addr),
    .calc_be   (calc_be),
    .calc_wdata(calc_wdata)
  );

  pslg_out_stage #(.OUT_REG(OUT_REG), .NB(NB), .ADDR_W(ADDR_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d_addr  (calc_addr),
    .d_be    (calc_be),
    .d_wdata (calc_wdata),
    .q_valid (out_valid),
    .q_addr  (out_addr),
    .q_be    (out_be),
    .q_wdata (out_wdata)
  );

  // Named wires for the assertions: lane index and expected byte count
  logic [3:0] chk_top, chk_m, chk_k, chk_cnt;
  logic [LW-1:0] chk_anchor;
  logic [7:0] chk_be8;
  assign chk_top    = in_op[OP_DBL_BIT] ? 4'd7 : 4'd3;
  assign chk_m      = in_op[OP_DBL_BIT] ? {1'b0, in_addr[2:0]} : {2'b00, in_addr[1:0]};
  assign chk_k      = in_big ? chk_m : (chk_m ^ chk_top);
  assign chk_cnt    = in_op[OP_RIGHT_BIT] ? (chk_k + 4'd1) : (chk_top + 4'd1 - chk_k);
  assign chk_anchor = in_addr[LW-1:0];
  assign chk_be8    = 8'(calc_be);

  a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && calc_ok |-> $countones(calc_be) == 32'(chk_cnt));

  a_r4_anchor: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && calc_ok |-> calc_be[chk_anchor]);

  a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> contiguous(chk_be8));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_be == '0);

  generate
    if (OUT_REG) begin : g_a_lat1
      a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    end else begin : g_a_lat0
      a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> out_valid);
    end
    if (!WIDE_EN) begin : g_a_narrow
      a_r11_wide_off: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op[OP_DBL_BIT] |-> calc_be == '0);
    end
  endgenerate

endmodule

// File: tb/sim_pslg_top.sv
module sim_pslg_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] in_addr = '0;
  logic        in_big = 1'b0;
  logic [63:0] in_data = '0;

  logic        v0, v1;
  logic [31:0] a0, a1;
  logic [7:0]  be0;
  logic [3:0]  be1;
  logic [63:0] wd0;
  logic [31:0] wd1;

  pslg_top #(.WIDE_EN(1'b1), .OUT_REG(1'b1), .ADDR_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_addr(in_addr), .in_big(in_big), .in_data(in_data),
    .out_valid(v0), .out_addr(a0), .out_be(be0), .out_wdata(wd0));

  pslg_top #(.WIDE_EN(1'b0), .OUT_REG(1'b0), .ADDR_W(32)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_addr(in_addr), .in_big(in_big), .in_data(in_data[31:0]),
    .out_valid(v1), .out_addr(a1), .out_be(be1), .out_wdata(wd1));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Walks the store one byte at a time, as the requirements describe it
  task automatic model(input int nbus, input logic [1:0] op, input logic [31:0] addr,
                       input logic big, input logic [63:0] data,
                       output logic [7:0] be, output logic [63:0] wd);
    int n, m, k, base, cnt, dir;
    bit left;
    be = '0; wd = '0;
    left = !op[0];
    if (op[1] && nbus == 4) return;
    n = op[1] ? 8 : 4;
    m = int'(addr) % n;
    base = (nbus == 8 && !op[1]) ? 4 * int'(addr[2]) : 0;
    k = big ? m : (m ^ (n - 1));
    if (left) begin cnt = n - k; dir = big ? 1 : -1; end
    else      begin cnt = k + 1; dir = big ? -1 : 1; end
    for (int s = 0; s < cnt; s++) begin
      int lane, rb;
      lane = base + m + dir * s;
      rb   = left ? (n - 1 - s) : s;
      be[lane] = 1'b1;
      wd[lane*8 +: 8] = data[rb*8 +: 8];
    end
  endtask

  function automatic bit is_contig(input logic [7:0] v);
    int first, last, cnt;
    first = -1; last = -1; cnt = 0;
    for (int i = 0; i < 8; i++) if (v[i]) begin
      if (first < 0) first = i;
      last = i; cnt++;
    end
    return (cnt == 0) || (last - first + 1 == cnt);
  endfunction

  // One operation: u1 sampled in the same cycle, u0 after the next edge
  task automatic run_op(input string req, input logic [1:0] op, input logic [31:0] addr,
                        input logic big, input logic [63:0] data, input bit use_u1);
    logic [7:0] eb0, eb1; logic [63:0] ew0, ew1;
    model(8, op, addr, big, data, eb0, ew0);
    model(4, op, addr, big, {32'h0, data[31:0]}, eb1, ew1);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_addr = addr; in_big = big; in_data = data;
    #1;
    if (use_u1) begin
      chk(req, "u1 be", {56'h0, be1}, {56'h0, eb1[3:0]});
      chk(req, "u1 wdata", {32'h0, wd1}, {32'h0, ew1[31:0]});
      chk("R8", "u1 addr", {32'h0, a1}, {32'h0, addr & ~32'd3});
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk(req, "u0 be", {56'h0, be0}, {56'h0, eb0});
    chk(req, "u0 wdata", wd0, ew0);
    chk("R8", "u0 addr", {32'h0, a0}, {32'h0, addr & ~32'd7});
    chk("R4", "u0 anchor lane", {63'h0, be0[addr[2:0]]}, 64'h1);
    chk("R5", "u0 contiguous", {63'h0, is_contig(be0)}, 64'h1);
  endtask

  task automatic t_reset;
    #1;
    chk("R9", "u0 valid in reset", {63'h0, v0}, 64'h0);
    chk("R9", "u0 be in reset", {56'h0, be0}, 64'h0);
  endtask

  task automatic t_sweep32;
    for (int hi = 0; hi < 2; hi++)
      for (int e = 0; e < 2; e++)
        for (int r = 0; r < 2; r++)
          for (int o = 0; o < 4; o++)
            run_op(r ? "R3" : "R2", {1'b0, r[0]}, 32'h1000 + 32'(hi * 4 + o),
                   e[0], 64'h8877665544332211, 1'b1);
    // R1: little-endian offset 1 left store gives k=2, so two bytes
    run_op("R1", 2'b00, 32'h2001, 1'b0, 64'h00000000a1b2c3d4, 1'b1);
    chk("R1", "u1 LE left count", {56'h0, be1}, 64'h3);
  endtask

  task automatic t_aligned;
    run_op("R6", 2'b00, 32'h3000, 1'b1, 64'hdeadbeefcafef00d, 1'b1);
    chk("R6", "BE left full word", {56'h0, be0}, 64'h0f);
    run_op("R6", 2'b01, 32'h3004, 1'b0, 64'hdeadbeefcafef00d, 1'b1);
    chk("R6", "LE right full word", {56'h0, be0}, 64'hf0);
    chk("R6", "LE right data", wd0, 64'hcafef00d_00000000);
  endtask

  task automatic t_sweep64;
    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++)
        for (int o = 0; o < 8; o++)
          run_op("R7", {1'b1, r[0]}, 32'h4000 + 32'(o), e[0],
                 64'h0f1e2d3c4b5a6978, 1'b0);
    run_op("R7", 2'b10, 32'h4003, 1'b1, 64'h0f1e2d3c4b5a6978, 1'b0);
    chk("R7", "BE dbl left offset 3", {56'h0, be0}, 64'hf8);
  endtask

  task automatic t_idle;
    @(negedge clk);
    in_valid = 1'b0; in_op = 2'b00; in_addr = 32'h5000; in_big = 1'b1;
    in_data = 64'hffffffffffffffff;
    #1;
    chk("R9", "u1 idle valid", {63'h0, v1}, 64'h0);
    chk("R9", "u1 idle be", {60'h0, be1}, 64'h0);
    @(posedge clk); #1;
    chk("R9", "u0 idle valid", {63'h0, v0}, 64'h0);
    chk("R9", "u0 idle be", {56'h0, be0}, 64'h0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b01; in_addr = 32'h6002; in_big = 1'b1;
    in_data = 64'h1122334455667788;
    #1;
    chk("R10", "u1 same-cycle valid", {63'h0, v1}, 64'h1);
    chk("R10", "u0 not yet valid", {63'h0, v0}, 64'h0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk("R10", "u0 valid after edge", {63'h0, v0}, 64'h1);
    @(posedge clk); #1;
    chk("R10", "u0 drops after one cycle", {63'h0, v0}, 64'h0);
  endtask

  task automatic t_wide_off;
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b10; in_addr = 32'h7000; in_big = 1'b1;
    in_data = 64'h1122334455667788;
    #1;
    chk("R11", "u1 valid on dbl", {63'h0, v1}, 64'h1);
    chk("R11", "u1 be zero on dbl", {60'h0, be1}, 64'h0);
    chk("R11", "u1 wdata zero on dbl", {32'h0, wd1}, 64'h0);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_sweep32();
    t_aligned();
    t_sweep64();
    t_idle();
    t_latency();
    t_wide_off();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule